// File: doc/BRIEF.md
# Oscillator Trim Calibration Engine

This block tunes an on-chip oscillator without software help. Its clock is the oscillator under trim. It counts that clock against a reference signal whose period is known, compares the count with a programmed expected count and tolerance, and steps a 5-bit signed trim code one notch at a time until the measured count falls inside the tolerance band.

There are two ways to take a measurement. In capture mode, a free-running cycle counter is sampled on two successive reference edges and the two samples are subtracted. In overflow mode, a window counter and a reference-edge counter are cleared together. When the reference-edge counter reaches a programmed window length, the window count is read.

After every trim step the engine waits a programmable number of reference edges before it measures again. Nothing signals when the oscillator has reached its new frequency, so this wait is the only guard. The engine reports success once two measurements in a row fall inside the tolerance. It reports saturation when the code is pinned at a signed limit and the next step would push past it.

Top module: `trim_cal_engine`

## Requirements
- R1: A reference edge is a rising edge of `refTick`. In capture mode (`useOverflow`=0), the measured count is the number of clock cycles between two consecutive reference edges. It is formed as the difference of two samples of a free-running counter.
- R2: In overflow mode (`useOverflow`=1), both counters clear on the arming edge. The window count is read when `windowTicks` further reference edges have arrived, so the measurement covers `windowTicks` reference periods. A `windowTicks` of 0 acts as 1.
- R3: When the measured count exceeds `expCount + tolerance`, the oscillator is too fast and `trimCode` is decremented by one.
- R4: When the measured count is below `expCount - tolerance`, the oscillator is too slow and `trimCode` is incremented by one.
- R5: When the measured count differs from `expCount` by at most `tolerance`, the measurement is in band and `trimCode` stays unchanged. A difference exactly equal to the tolerance counts as in band.
- R6: `trimCode` is two's complement. 5'b01111 is the fastest setting, 5'b00000 is the centre, 5'b10000 is the slowest, and reset loads 5'b00000. A step past a limit is blocked: the code holds, `saturated` rises and the engine stops with `done` low.
- R7: `done` rises after two consecutive in-band measurements. The engine then stops, and `done` stays high until the next start.
- R8: A one-cycle `start` pulse clears `done` and `saturated` and begins a new run from the present `trimCode`.
- R9: After each trim step the engine lets `settleTicks` reference edges pass before it arms the next measurement. A value of 0 selects the default of 2 edges. Consecutive steps in capture mode are therefore `settle+2` reference edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator being trimmed |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference signal of known period, synchronous to `clk` |
| start | input | 1 | One-cycle pulse that begins a calibration run |
| useOverflow | input | 1 | 0 selects capture mode, 1 selects overflow mode |
| expCount | input | 16 | Expected clock count per measurement |
| tolerance | input | 16 | Allowed absolute deviation from `expCount` |
| windowTicks | input | 8 | Reference periods per window in overflow mode |
| settleTicks | input | 8 | Reference edges to wait after a step (0 selects the default) |
| trimCode | output | 5 | Two's-complement oscillator trim code |
| done | output | 1 | Calibration converged |
| saturated | output | 1 | A step was blocked at a trim limit |

## Verification
The testbench models the oscillator as a reference period of `base + 4*trim` clock cycles, with the period recomputed on every reference pulse. The stimulus table covers several cases:
- A start already in band, checking that the engine leaves the code alone.
- Targets above and below the start point, checking both step directions.
- Targets beyond either end of the code range, which must end in saturation rather than wrap-around.
- A tolerance hit exactly and missed by one, separating inclusive from exclusive comparison.
- Overflow-mode runs with multi-period and zero-length windows, confirming the count spans the window.

Directed runs then measure how many reference edges separate consecutive trim steps, for the default and an explicit settle count. A final directed run restarts from a converged code, which shows that a run resumes from the present trim rather than the centre.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ARM,
    ST_MEAS,
    ST_EVAL
  } calState_t;

  typedef struct packed {
    logic clearWin;
    logic capFirst;
    logic countRef;
    logic latchMeas;
    logic stepUp;
    logic stepDn;
  } calStrobe_t;
endpackage

// File: rtl/trim_cal_datapath.sv
module trim_cal_datapath
  import trim_cal_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REF_W  = 8,
  parameter int TRIM_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              useOverflow,
  input  logic [CNT_W-1:0]  expCount,
  input  logic [CNT_W-1:0]  tolerance,
  input  logic [REF_W-1:0]  windowTicks,
  input  calStrobe_t        strobe,
  output logic              refEdge,
  output logic              winFull,
  output logic              tooFast,
  output logic              tooSlow,
  output logic              atMax,
  output logic              atMin,
  output logic [TRIM_W-1:0] trimCode
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic [TRIM_W-1:0] TRIM_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [TRIM_W-1:0] TRIM_ONE = TRIM_W'(1);

  logic              refPrev;
  logic [CNT_W-1:0]  freeCnt;
  logic [CNT_W-1:0]  firstCap;
  logic [CNT_W-1:0]  winCnt;
  logic [REF_W-1:0]  refCnt;
  logic [CNT_W-1:0]  measQ;
  logic [TRIM_W-1:0] trimQ;
  logic [REF_W:0]    winLen;
  logic [CNT_W:0]    upperLim;
  logic [CNT_W:0]    measPlusTol;

  assign refEdge = refTick & ~refPrev;

  // window length, zero treated as one period
  assign winLen  = (windowTicks == '0) ? (REF_W+1)'(1) : {1'b0, windowTicks};
  assign winFull = ({1'b0, refCnt} + (REF_W+1)'(1)) >= winLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev  <= 1'b0;
      freeCnt  <= '0;
      firstCap <= '0;
      winCnt   <= '0;
      refCnt   <= '0;
      measQ    <= '0;
    end else begin
      refPrev <= refTick;
      freeCnt <= freeCnt + CNT_W'(1);
      if (strobe.clearWin) begin
        winCnt <= CNT_W'(1);
        refCnt <= '0;
      end else begin
        winCnt <= winCnt + CNT_W'(1);
        if (strobe.countRef) refCnt <= refCnt + REF_W'(1);
      end
      if (strobe.capFirst) firstCap <= freeCnt;
      if (strobe.latchMeas)
        measQ <= useOverflow ? winCnt : (freeCnt - firstCap);
    end
  end

  // tolerance band comparison, one extra bit to avoid overflow
  assign upperLim    = {1'b0, expCount} + {1'b0, tolerance};
  assign measPlusTol = {1'b0, measQ} + {1'b0, tolerance};
  assign tooFast     = {1'b0, measQ} > upperLim;
  assign tooSlow     = measPlusTol < {1'b0, expCount};

  assign atMax = (trimQ == TRIM_MAX);
  assign atMin = (trimQ == TRIM_MIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trimQ <= '0;
    end else if (strobe.stepUp && !atMax) begin
      trimQ <= trimQ + TRIM_ONE;
    end else if (strobe.stepDn && !atMin) begin
      trimQ <= trimQ - TRIM_ONE;
    end
  end

  assign trimCode = trimQ;

  // R6: the code moves by exactly one notch whenever it moves
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(trimQ) |-> ((trimQ == $past(trimQ) + TRIM_ONE) ||
                         (trimQ == $past(trimQ) - TRIM_ONE)));

  // R3: a downward step follows a too-fast measurement
  a_r3_down_after_fast: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(trimQ) && (trimQ == $past(trimQ) - TRIM_ONE)) |-> $past(tooFast));

  // R4: an upward step follows a too-slow measurement
  a_r4_up_after_slow: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(trimQ) && (trimQ == $past(trimQ) + TRIM_ONE)) |-> $past(tooSlow));

  // R6: no wrap between the signed limits
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(trimQ) == TRIM_MAX) |-> (trimQ != TRIM_MIN));
endmodule

// File: rtl/trim_cal_control.sv
module trim_cal_control
  import trim_cal_pkg::*;
#(
  parameter int REF_W     = 8,
  parameter int SETTLE_DEF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             useOverflow,
  input  logic [REF_W-1:0] settleTicks,
  input  logic             refEdge,
  input  logic             winFull,
  input  logic             tooFast,
  input  logic             tooSlow,
  input  logic             atMax,
  input  logic             atMin,
  output calStrobe_t       strobe,
  output logic             done,
  output logic             saturated
);
  calState_t        state, stateNext;
  logic [REF_W-1:0] settleLeft, settleLeftNext;
  logic [REF_W-1:0] settleLoad;
  logic             inRow, inRowNext;
  logic             doneQ, doneNext;
  logic             satQ, satNext;

  assign settleLoad = (settleTicks == '0) ? REF_W'(SETTLE_DEF) : settleTicks;

  always_comb begin
    stateNext      = state;
    settleLeftNext = settleLeft;
    inRowNext      = inRow;
    doneNext       = doneQ;
    satNext        = satQ;
    strobe         = '0;
    if (start) begin
      stateNext = ST_ARM;
      inRowNext = 1'b0;
      doneNext  = 1'b0;
      satNext   = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_SETTLE: begin
          if (refEdge) begin
            if (settleLeft <= REF_W'(1)) stateNext = ST_ARM;
            else settleLeftNext = settleLeft - REF_W'(1);
          end
        end
        ST_ARM: begin
          if (refEdge) begin
            strobe.clearWin = 1'b1;
            strobe.capFirst = 1'b1;
            stateNext       = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (refEdge) begin
            if (!useOverflow || winFull) begin
              strobe.latchMeas = 1'b1;
              stateNext        = ST_EVAL;
            end else begin
              strobe.countRef = 1'b1;
            end
          end
        end
        ST_EVAL: begin
          if (tooFast || tooSlow) begin
            inRowNext = 1'b0;
            if ((tooFast && atMin) || (tooSlow && atMax)) begin
              satNext   = 1'b1;
              stateNext = ST_IDLE;
            end else begin
              strobe.stepDn  = tooFast;
              strobe.stepUp  = tooSlow;
              settleLeftNext = settleLoad;
              stateNext      = ST_SETTLE;
            end
          end else if (inRow) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            inRowNext = 1'b1;
            stateNext = ST_ARM;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      settleLeft <= '0;
      inRow      <= 1'b0;
      doneQ      <= 1'b0;
      satQ       <= 1'b0;
    end else begin
      state      <= stateNext;
      settleLeft <= settleLeftNext;
      inRow      <= inRowNext;
      doneQ      <= doneNext;
      satQ       <= satNext;
    end
  end

  assign done      = doneQ;
  assign saturated = satQ;

  // R7: success and saturation never coexist
  a_r7_done_not_sat: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && satQ));

  // R6: saturation is only reported with the code pinned at a limit
  a_r6_sat_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    satQ |-> (atMax || atMin));

  // R8: a start pulse clears both flags on the next cycle
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!doneQ && !satQ));

  // R7: done holds until a start arrives
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !start) |=> doneQ);
endmodule

// File: rtl/trim_cal_engine.sv
module trim_cal_engine
  import trim_cal_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int REF_W      = 8,
  parameter int TRIM_W     = 5,
  parameter int SETTLE_DEF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              start,
  input  logic              useOverflow,
  input  logic [CNT_W-1:0]  expCount,
  input  logic [CNT_W-1:0]  tolerance,
  input  logic [REF_W-1:0]  windowTicks,
  input  logic [REF_W-1:0]  settleTicks,
  output logic [TRIM_W-1:0] trimCode,
  output logic              done,
  output logic              saturated
);
  calStrobe_t strobe;
  logic refEdge, winFull, tooFast, tooSlow, atMax, atMin;

  trim_cal_datapath #(
    .CNT_W (CNT_W),
    .REF_W (REF_W),
    .TRIM_W(TRIM_W)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .useOverflow(useOverflow),
    .expCount   (expCount),
    .tolerance  (tolerance),
    .windowTicks(windowTicks),
    .strobe     (strobe),
    .refEdge    (refEdge),
    .winFull    (winFull),
    .tooFast    (tooFast),
    .tooSlow    (tooSlow),
    .atMax      (atMax),
    .atMin      (atMin),
    .trimCode   (trimCode)
  );

  trim_cal_control #(
    .REF_W     (REF_W),
    .SETTLE_DEF(SETTLE_DEF)
  ) control_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .useOverflow(useOverflow),
    .settleTicks(settleTicks),
    .refEdge    (refEdge),
    .winFull    (winFull),
    .tooFast    (tooFast),
    .tooSlow    (tooSlow),
    .atMax      (atMax),
    .atMin      (atMin),
    .strobe     (strobe),
    .done       (done),
    .saturated  (saturated)
  );
endmodule

// File: tb/trim_cal_engine_tb_top.sv
`timescale 1ns/1ps
module trim_cal_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        refTick;
  logic        start;
  logic        useOverflow;
  logic [15:0] expCount;
  logic [15:0] tolerance;
  logic [7:0]  windowTicks;
  logic [7:0]  settleTicks;
  logic [4:0]  trimCode;
  logic        done;
  logic        saturated;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // oscillator model state
  bit genEn = 1'b0;
  int base  = 100;
  int genCnt = 0;
  // settle-gap monitor
  int gapExp = 0;
  int gapErr = 0;
  int gapSeen = 0;
  int pulsesSince = 0;
  bit haveChange = 1'b0;
  logic [4:0] lastTrim = '0;

  always #2 clk = ~clk;

  trim_cal_engine dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .start(start),
    .useOverflow(useOverflow), .expCount(expCount), .tolerance(tolerance),
    .windowTicks(windowTicks), .settleTicks(settleTicks),
    .trimCode(trimCode), .done(done), .saturated(saturated)
  );

  // stimulus table: mode, base, expected count, tol, window, final trim, saturated
  localparam int NV = 10;
  localparam int V_MODE[NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
  localparam int V_BASE[NV] = '{100, 100, 100, 100, 100, 50, 60, 100, 100, 100};
  localparam int V_EXP [NV] = '{100, 120, 80, 200, 10, 186, 104, 104, 105, 120};
  localparam int V_TOL [NV] = '{1, 1, 2, 1, 1, 2, 1, 4, 4, 1};
  localparam int V_WIN [NV] = '{1, 1, 1, 1, 1, 3, 2, 1, 1, 0};
  localparam int V_TRIM[NV] = '{0, 5, -5, 15, -16, 3, -2, 0, 1, 5};
  localparam int V_SAT [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference generator: period base + 4*trim cycles, plus gap monitor
  always @(negedge clk) begin
    cycles++;
    if (trimCode != lastTrim) begin
      if (haveChange && gapExp != 0) begin
        gapSeen++;
        if (pulsesSince != gapExp) gapErr++;
      end
      haveChange  = 1'b1;
      pulsesSince = 0;
      lastTrim    = trimCode;
    end
    if (!genEn) begin
      genCnt  = 0;
      refTick = 1'b0;
    end else if (genCnt == 0) begin
      refTick = 1'b1;
      pulsesSince++;
      genCnt = base + 4 * int'($signed(trimCode)) - 1;
    end else begin
      refTick = 1'b0;
      genCnt--;
    end
  end

  task automatic doReset();
    genEn = 1'b0;
    rstN  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lastTrim = trimCode;
    @(negedge clk);
  endtask

  task automatic runCal(input int timeout);
    haveChange = 1'b0;
    gapErr = 0;
    gapSeen = 0;
    genEn = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < timeout; k++) begin
      if (done || saturated) break;
      @(negedge clk);
    end
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; useOverflow = 1'b0;
    expCount = '0; tolerance = '0; windowTicks = 8'd1; settleTicks = '0;
    doReset();
    chk("R6 reset trim", int'(trimCode), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R6 reset saturated", int'(saturated), 0);

    // R1 R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NV; i++) begin
      doReset();
      useOverflow = V_MODE[i][0];
      base        = V_BASE[i];
      expCount    = 16'(V_EXP[i]);
      tolerance   = 16'(V_TOL[i]);
      windowTicks = 8'(V_WIN[i]);
      settleTicks = 8'd0;
      runCal(40000);
      chk($sformatf("R1/R2/R3/R4/R5 vec%0d trim", i), int'($signed(trimCode)), V_TRIM[i]);
      chk($sformatf("R6 vec%0d saturated", i), int'(saturated), V_SAT[i]);
      chk($sformatf("R7 vec%0d done", i), int'(done), 1 - V_SAT[i]);
    end

    // R9: default settle of 2 gives steps 4 reference edges apart
    doReset();
    useOverflow = 1'b0; base = 100; expCount = 16'd120; tolerance = 16'd1;
    windowTicks = 8'd1; settleTicks = 8'd0; gapExp = 4;
    runCal(40000);
    chk("R9 default gaps seen", gapSeen, 4);
    chk("R9 default gap errors", gapErr, 0);

    // R9: explicit settle of 3 gives 5 edges apart
    doReset();
    settleTicks = 8'd3; gapExp = 5;
    runCal(40000);
    chk("R9 settle3 gaps seen", gapSeen, 4);
    chk("R9 settle3 gap errors", gapErr, 0);
    chk("R9 settle3 trim", int'($signed(trimCode)), 5);
    gapExp = 0;

    // R8: restart from the converged code without reset
    expCount = 16'd128; settleTicks = 8'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 start clears done", int'(done), 0);
    for (int k = 0; k < 40000; k++) begin
      if (done || saturated) break;
      @(negedge clk);
    end
    chk("R8 restart trim", int'($signed(trimCode)), 7);
    chk("R8 restart done", int'(done), 1);

    // R8: start clears saturated
    expCount = 16'd1000;
    runCal(40000);
    chk("R6 high target saturated", int'(saturated), 1);
    chk("R6 high target trim", int'($signed(trimCode)), 15);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 start clears saturated", int'(saturated), 0);

    genEn = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule